// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds the per-processor pending state for two interrupt classes in a system of up to four processors: inter-processor interrupts (IPIs), raised by one processor against any set of others, and a periodic timer interrupt that a tick input posts to every processor at once. Each class has its own pending vector with one bit per processor. Each bit drives a level output, so IPIs and timer interrupts reach a processor on two separate lines, apart from the device interrupt line.

Software reaches the block through a simple one-request-per-cycle register port. The control register takes three processor-mask fields. One write to it can request IPIs, clear IPIs and clear timer interrupts together. Dedicated registers read back the two pending vectors, clear bits by mask, and post IPIs by mask. Redundant operations leave the state as it was but set a sticky warning flag. Writes that carry no operation set a sticky unsupported flag. Both flags sit in a flag register that clears when read.

Top module: `icx_top`

## Requirements
- R1: After reset both pending vectors are zero, every `ipi_irq` and `tmr_irq` bit is low, `rsp_vld` is low and the flag register reads 0.
- R2: A write to register select 0 (control) with bit 12+n set posts an IPI to processor n. `ipi_irq[n]` is high from the clock edge that takes the write onward.
- R3: Control bit 8+n clears processor n's IPI. When a single write both requests and clears the same processor, the request is applied first and the clear second, so that processor ends the write with no IPI pending.
- R4: Control bit 4+n clears processor n's timer interrupt. Processors not named keep their state, and clearing a processor that has nothing pending is not flagged.
- R5: A high `tick` in a cycle sets every processor's timer pending bit. If a timer clear arrives in the same cycle, the tick wins.
- R6: Every read request yields exactly one `rsp_vld` pulse in the next cycle. A control-register read returns the requesting processor's `req_cpu` in bits 1:0, with all other bits zero.
- R7: Select 1 reads the IPI pending vector in its low bits, and a write to it clears the named bits. Select 2 does the same for the timer pending vector. A write to select 3 posts IPIs to the processors named in its low bits.
- R8: Requesting an IPI that is already pending, or clearing one that is not, changes no state and sets flag bit 0. Select 4 reads the flags {unsupported, warning} in bits 1:0 and clears them.
- R9: A control write with bits 15:4 all zero is unsupported when bit 28 is also zero: it sets flag bit 1 and changes nothing. With bit 28 set it is accepted silently. A write to selects 5 to 7 also sets flag bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Register access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Register select |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 2 | Number of the requesting processor |
| tick | input | 1 | Timer tick, one cycle per period |
| rsp_vld | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ipi_irq | output | 4 | IPI level per processor |
| tmr_irq | output | 4 | Timer interrupt level per processor |

## Verification
Writes and ticks reach the pending registers on the clock edge that takes them, so `ipi_irq` and `tmr_irq` are due one edge after the stimulus. The bench samples them at the falling edge that follows. Read data is registered and is due, with `rsp_vld`, in the cycle after the request. Each read therefore pushes its expected value into a scoreboard queue at the moment it is issued. A falling-edge monitor pops an entry on each `rsp_vld`, and the queue must be empty at the end. Expected values come from a bench model of the pending vectors and flags, built from the requirements and applied in the same request-then-clear order.

// File: rtl/icx_pkg.sv
package icx_pkg;
  localparam int unsigned FIELD_W      = 4;
  localparam int unsigned POST_LSB     = 12;
  localparam int unsigned IPI_CLR_LSB  = 8;
  localparam int unsigned TMR_CLR_LSB  = 4;
  localparam int unsigned ERR_ACK_BIT  = 28;

  typedef enum logic [2:0] {
    SEL_CTRL     = 3'd0,
    SEL_IPI_PEND = 3'd1,
    SEL_TMR_PEND = 3'd2,
    SEL_IPI_POST = 3'd3,
    SEL_FLAGS    = 3'd4
  } icx_sel_e;
endpackage

// File: rtl/icx_cmd_decode.sv
module icx_cmd_decode
  import icx_pkg::*;
#(
  parameter int unsigned NCPU = 4,
  parameter int unsigned DW   = 32
) (
  input  logic            req_vld,
  input  logic            req_wr,
  input  logic [2:0]      req_sel,
  input  logic [DW-1:0]   req_wdata,
  output logic [NCPU-1:0] ipi_post_m,
  output logic [NCPU-1:0] ipi_clr_m,
  output logic [NCPU-1:0] tmr_clr_m,
  output logic            unsup,
  output logic            flags_rd
);
  logic wr_en;
  logic ctrl_empty;

  always_comb begin
    wr_en      = req_vld && req_wr;
    ipi_post_m = '0;
    ipi_clr_m  = '0;
    tmr_clr_m  = '0;
    unsup      = 1'b0;
    flags_rd   = req_vld && !req_wr && (req_sel == SEL_FLAGS);
    ctrl_empty = (req_wdata[POST_LSB +: FIELD_W] == '0) &&
                 (req_wdata[IPI_CLR_LSB +: FIELD_W] == '0) &&
                 (req_wdata[TMR_CLR_LSB +: FIELD_W] == '0) &&
                 !req_wdata[ERR_ACK_BIT];
    if (wr_en) begin
      case (req_sel)
        SEL_CTRL: begin
          ipi_post_m = req_wdata[POST_LSB +: NCPU];
          ipi_clr_m  = req_wdata[IPI_CLR_LSB +: NCPU];
          tmr_clr_m  = req_wdata[TMR_CLR_LSB +: NCPU];
          unsup      = ctrl_empty;
        end
        SEL_IPI_PEND: ipi_clr_m  = req_wdata[NCPU-1:0];
        SEL_TMR_PEND: tmr_clr_m  = req_wdata[NCPU-1:0];
        SEL_IPI_POST: ipi_post_m = req_wdata[NCPU-1:0];
        SEL_FLAGS:    unsup      = 1'b0;
        default:      unsup      = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/icx_ipi_bank.sv
module icx_ipi_bank #(
  parameter int unsigned NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] post_m,
  input  logic [NCPU-1:0] clr_m,
  output logic [NCPU-1:0] pend_q,
  output logic            warn
);
  logic [NCPU-1:0] after_post;
  logic [NCPU-1:0] pend_d;
  logic            pend_en;

  always_comb begin
    after_post = pend_q | post_m;
    pend_d     = after_post & ~clr_m;
    pend_en    = (post_m != '0) || (clr_m != '0);
    warn       = ((post_m & pend_q) != '0) || ((clr_m & ~after_post) != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  p_post_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (post_m != '0) |=> ((~pend_q & $past(post_m & ~clr_m)) == '0));

  p_clear_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_m != '0) |=> ((pend_q & $past(clr_m)) == '0));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (post_m == '0 && clr_m == '0) |=> $stable(pend_q));
endmodule

// File: rtl/icx_tmr_bank.sv
module icx_tmr_bank #(
  parameter int unsigned NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NCPU-1:0] clr_m,
  output logic [NCPU-1:0] pend_q
);
  logic [NCPU-1:0] pend_d;
  logic            pend_en;

  always_comb begin
    pend_en = tick || (clr_m != '0);
    pend_d  = tick ? {NCPU{1'b1}} : (pend_q & ~clr_m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  p_tick_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pend_q == {NCPU{1'b1}}));

  p_clear_named_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && clr_m != '0) |=> ((pend_q & $past(clr_m)) == '0));

  p_others_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick) |=> ((pend_q & ~$past(clr_m)) == ($past(pend_q) & ~$past(clr_m))));
endmodule

// File: rtl/icx_top.sv
module icx_top
  import icx_pkg::*;
#(
  parameter int unsigned NCPU = 4,
  parameter int unsigned DW   = 32,
  localparam int unsigned CW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic            req_wr,
  input  logic [2:0]      req_sel,
  input  logic [DW-1:0]   req_wdata,
  input  logic [CW-1:0]   req_cpu,
  input  logic            tick,
  output logic            rsp_vld,
  output logic [DW-1:0]   rsp_rdata,
  output logic [NCPU-1:0] ipi_irq,
  output logic [NCPU-1:0] tmr_irq
);
  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic [NCPU-1:0] ipi_post_m, ipi_clr_m, tmr_clr_m;
  logic            unsup, flags_rd, ipi_warn;
  logic [1:0]      flags_q, flags_d;
  logic            rd_en;
  logic [DW-1:0]   rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  icx_cmd_decode #(.NCPU(NCPU), .DW(DW)) u_dec (
    .req_vld    (req_vld),
    .req_wr     (req_wr),
    .req_sel    (req_sel),
    .req_wdata  (req_wdata),
    .ipi_post_m (ipi_post_m),
    .ipi_clr_m  (ipi_clr_m),
    .tmr_clr_m  (tmr_clr_m),
    .unsup      (unsup),
    .flags_rd   (flags_rd)
  );

  icx_ipi_bank #(.NCPU(NCPU)) u_ipi (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .post_m (ipi_post_m),
    .clr_m  (ipi_clr_m),
    .pend_q (ipi_irq),
    .warn   (ipi_warn)
  );

  icx_tmr_bank #(.NCPU(NCPU)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick),
    .clr_m  (tmr_clr_m),
    .pend_q (tmr_irq)
  );

  always_comb begin
    rd_en   = req_vld && !req_wr;
    flags_d = flags_rd ? 2'b00 : (flags_q | {unsup, ipi_warn});
    rdata_d = '0;
    case (req_sel)
      SEL_CTRL:     rdata_d[CW-1:0]   = req_cpu;
      SEL_IPI_PEND: rdata_d[NCPU-1:0] = ipi_irq;
      SEL_TMR_PEND: rdata_d[NCPU-1:0] = tmr_irq;
      SEL_FLAGS:    rdata_d[1:0]      = flags_q;
      default:      rdata_d           = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_q   <= '0;
      rsp_vld   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      flags_q <= flags_d;
      rsp_vld <= rd_en;
      if (rd_en) rsp_rdata <= rdata_d;
    end
  end

  p_rsp_next_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en |=> rsp_vld);

  p_rsp_only_read_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> !rsp_vld);

  p_flags_cleared_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flags_rd |=> (flags_q == 2'b00));

  p_unsup_sticky_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    unsup |=> flags_q[1]);
endmodule

// File: tb/test_icx_top.sv
module test_icx_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, req_wr, tick;
  logic [2:0]  req_sel;
  logic [31:0] req_wdata;
  logic [1:0]  req_cpu;
  logic        rsp_vld;
  logic [31:0] rsp_rdata;
  logic [3:0]  ipi_irq, tmr_irq;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  logic [3:0] ipi_m = '0, tmr_m = '0;
  logic [1:0] flg_m = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  icx_top i_icx_top (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_sel(req_sel), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .tick(tick), .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata),
    .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses arrive
  always @(negedge clk) begin
    if (rst_n && rsp_vld) begin
      if (exp_q.size() == 0) chk("R6 unexpected response", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic model_write(input logic [2:0] sel, input logic [31:0] d);
    logic [3:0] s, c, t;
    s = '0; c = '0; t = '0;
    case (sel)
      3'd0: begin
        s = d[15:12]; c = d[11:8]; t = d[7:4];
        if (d[15:4] == '0 && !d[28]) flg_m[1] = 1'b1;
      end
      3'd1: c = d[3:0];
      3'd2: t = d[3:0];
      3'd3: s = d[3:0];
      3'd4: ;
      default: flg_m[1] = 1'b1;
    endcase
    if ((s & ipi_m) != '0) flg_m[0] = 1'b1;
    ipi_m = ipi_m | s;
    if ((c & ~ipi_m) != '0) flg_m[0] = 1'b1;
    ipi_m = ipi_m & ~c;
    tmr_m = tmr_m & ~t;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d, input bit tk);
    @(negedge clk);
    req_vld = 1; req_wr = 1; req_sel = sel; req_wdata = d; req_cpu = 0; tick = tk;
    model_write(sel, d);
    if (tk) tmr_m = 4'hF;
    @(negedge clk);
    req_vld = 0; req_wr = 0; tick = 0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [1:0] cpu, input string tag);
    logic [31:0] e;
    e = '0;
    case (sel)
      3'd0: e[1:0] = cpu;
      3'd1: e[3:0] = ipi_m;
      3'd2: e[3:0] = tmr_m;
      3'd4: begin e[1:0] = flg_m; flg_m = 2'b00; end
      default: e = '0;
    endcase
    @(negedge clk);
    req_vld = 1; req_wr = 0; req_sel = sel; req_wdata = '0; req_cpu = cpu;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req_vld = 0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1; tmr_m = 4'hF;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic outs(input string tag);
    chk({tag, " ipi_irq"}, {28'd0, ipi_irq}, {28'd0, ipi_m});
    chk({tag, " tmr_irq"}, {28'd0, tmr_irq}, {28'd0, tmr_m});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; req_vld = 0; req_wr = 0; req_sel = 0; req_wdata = 0; req_cpu = 0; tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    outs("R1");
    chk("R1 rsp_vld", {31'd0, rsp_vld}, 32'd0);
    rd(3'd4, 2'd0, "R1 flags after reset");
    // R2 request IPIs to cpu0 and cpu1
    wr(3'd0, 32'h0000_3000, 0); outs("R2");
    rd(3'd1, 2'd0, "R7 ipi pending read");
    // R8 duplicate request
    wr(3'd0, 32'h0000_2000, 0); outs("R8 dup no change");
    rd(3'd4, 2'd0, "R8 warning flag set");
    rd(3'd4, 2'd0, "R8 flags cleared by read");
    // R3 clear cpu0, then request+clear cpu2
    wr(3'd0, 32'h0000_0100, 0); outs("R3 clear");
    wr(3'd0, 32'h0000_4400, 0); outs("R3 post then clear");
    rd(3'd4, 2'd0, "R3 no warning for post+clear");
    // R8 clear of non-pending IPI
    wr(3'd0, 32'h0000_0800, 0); outs("R8 miss no change");
    rd(3'd4, 2'd0, "R8 warning on miss");
    // R5 tick, R4 timer clear
    pulse_tick(); outs("R5 tick");
    wr(3'd0, 32'h0000_0050, 0); outs("R4 timer clear named");
    wr(3'd0, 32'h0000_0050, 0); outs("R4 clear not pending");
    rd(3'd4, 2'd0, "R4 no flag for timer miss");
    wr(3'd0, 32'h0000_0010, 1); outs("R5 tick wins over clear");
    // R7 dedicated registers
    wr(3'd2, 32'h0000_0001, 0); outs("R7 timer clear reg");
    rd(3'd2, 2'd0, "R7 timer pending read");
    wr(3'd3, 32'h0000_0009, 0); outs("R7 ipi post reg");
    wr(3'd1, 32'h0000_0002, 0); outs("R7 ipi clear reg");
    rd(3'd1, 2'd0, "R7 ipi pending after clear reg");
    rd(3'd4, 2'd0, "R7 flags after dedicated ops");
    // R9 error-ack only, empty write, undefined select
    wr(3'd0, 32'h1000_0000, 0); outs("R9 ack accepted");
    rd(3'd4, 2'd0, "R9 ack not flagged");
    wr(3'd0, 32'h0000_0000, 0); outs("R9 empty write no change");
    rd(3'd4, 2'd0, "R9 empty write flagged");
    wr(3'd6, 32'h0000_f0f0, 0); outs("R9 undefined select no change");
    rd(3'd4, 2'd0, "R9 undefined select flagged");
    // R6 control read returns requester
    rd(3'd0, 2'd2, "R6 cpu id 2");
    rd(3'd0, 2'd3, "R6 cpu id 3");
    rd(3'd3, 2'd1, "R6 post reg reads zero");
    repeat (3) @(negedge clk);
    chk("R6 all responses seen", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule